// File: doc/BRIEF.md
# Threshold-Armed Sample Capture Engine

The engine watches a stream of 16-bit sample words delivered by an upstream serial receiver, one word per cycle in which the valid strobe is high. Once started, it looks for a strong-signal event: a word whose upper byte is at or above a fixed amplitude threshold (240 by default). A programmable number of such events is passed over, so that the engine can lock onto a later burst rather than the first one.

After the event that counts, the engine lets a programmable number of further valid words go by. This holdoff lets the capture window open at a known distance after the burst. It then stores every following valid word at rising addresses of a buffer memory, starting at address 0, until the last location has been written. It finishes with a one-cycle done pulse and drops its activity output. The host normally asks it to pass over one event and 10000 words. Both counts are sampled when the engine is started.

Top module: `trig_capture`

## Requirements
- R1: A word is consumed only in a cycle where `s_valid` is 1; a cycle with `s_valid` at 0 changes neither the state, the skip counts nor the buffer, whatever `s_data` holds.
- R2: In the waiting state (code 1), a valid word is a trigger event when `s_data[15:8]` is 240 or more; a word with an upper byte of 239 or less leaves the engine waiting.
- R3: With `trig_skip` = N, latched at start, the first N trigger events are ignored and the next one is accepted.
- R4: After the accepted trigger, `samp_skip` = M further valid words (latched at start) are discarded in the holdoff state (code 2) before storage begins; with M = 0 the engine goes straight to the capture state (code 3). The trigger word itself is never stored, and words at trigger level during holdoff do not restart anything.
- R5: The holdoff counts only valid words; any number of cycles without `s_valid` keeps the engine in holdoff.
- R6: In capture, each valid word is written through `mem_we`/`mem_addr`/`mem_wdata` to consecutive addresses starting at 0, with `mem_wdata` equal to the word; exactly DEPTH writes happen, and `captured` counts them and never exceeds DEPTH.
- R7: In the cycle after the write to address DEPTH-1, `done_pulse` is 1 for exactly one cycle, `state` reads 4 (done) and `active` is 0.
- R8: `start` is acted on only in the idle (0) or done (4) state; in states 1 to 3 it has no effect. A start from done clears `captured` to 0 and re-arms the engine in state 1.
- R9: With `rst_n` low at a clock edge, the engine returns to idle: `state` 0, `captured` 0, `active` 0, no write and no done pulse.
- R10: `active` is 1 exactly in states 1, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Arms the engine from idle or done |
| trig_skip | input | TRIG_W | Trigger events to ignore, sampled at start |
| samp_skip | input | SKIP_W | Valid words to discard after the trigger, sampled at start |
| s_valid | input | 1 | Sample word strobe |
| s_data | input | DATA_W | Sample word |
| mem_we | output | 1 | Buffer write enable |
| mem_addr | output | $clog2(DEPTH) | Buffer write address |
| mem_wdata | output | DATA_W | Buffer write data |
| state | output | 3 | Current state code (0 idle, 1 wait, 2 holdoff, 3 capture, 4 done) |
| captured | output | $clog2(DEPTH)+1 | Words stored since the last start |
| done_pulse | output | 1 | One-cycle pulse when the buffer is full |
| active | output | 1 | High while armed, in holdoff or capturing |

## Verification
The hardest situation to reach from the ports is a start request arriving while the engine is deep in a run, together with long stretches of invalid cycles inside the holdoff, because both must land in a narrow state window. The bench parks the engine in holdoff with a three-word skip, idles the strobe for several cycles, and later fires `start` with different counts during capture, checking that state and count are unchanged. A vector table covering trigger-level words inside both holdoff and stored data, gap cycles between stored words, and back-to-back runs from the done state drives the main flow.

// File: rtl/trig_capture_pkg.sv
// Shared state encoding for the threshold-armed capture engine.
// Assumes: the state code is visible at the top-level port, so values are fixed.
package trig_capture_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WAIT = 3'd1,
        ST_HOLD = 3'd2,
        ST_CAPT = 3'd3,
        ST_DONE = 3'd4
    } cap_state_e;

endpackage

// File: rtl/tc_level_detect.sv
// Amplitude event detector: flags a valid word whose level field reaches THRESH.
// Assumes: the level field is unsigned and the caller passes only that field.
module tc_level_detect #(
    parameter int LVL_W  = 8,
    parameter int THRESH = 240
) (
    input  logic             valid,
    input  logic [LVL_W-1:0] level,
    output logic             hit
);

    localparam logic [LVL_W-1:0] THR = LVL_W'(THRESH);

    // Compare the level of a strobed word against the threshold.
    always_comb begin
        hit = valid && (level >= THR);
    end

endmodule

// File: rtl/tc_skip_counter.sv
// Loadable down counter used for both the trigger skip and the word holdoff.
// Assumes: load has priority over dec; the count never wraps below zero.
module tc_skip_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         at_zero,
    output logic         at_one
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt;

    // Hold, load or step the remaining count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && (cnt != '0)) begin
            cnt <= cnt - ONE;
        end
    end

    // Expose the two values the sequencer decides on.
    always_comb begin
        at_zero = (cnt == '0);
        at_one  = (cnt == ONE);
    end

endmodule

// File: rtl/tc_write_addr.sv
// Buffer address and fill counter for the capture phase.
// Assumes: inc is issued only while the buffer is not yet full.
module tc_write_addr #(
    parameter int DEPTH = 1024,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [AW-1:0] addr,
    output logic [CW-1:0] count,
    output logic          at_last
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    // Advance address and fill count together on every stored word.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            addr  <= '0;
            count <= '0;
        end else if (inc) begin
            addr  <= addr + AW'(1);
            count <= count + CW'(1);
        end
    end

    // Flag the final buffer location.
    always_comb begin
        at_last = (addr == LAST);
    end

endmodule

// File: rtl/trig_capture.sv
// Threshold-armed capture engine: wait for the accepted amplitude event,
// discard a holdoff of valid words, then fill the buffer once and report done.
// Assumes: one sample word per valid cycle; the buffer accepts a write each cycle;
// skip counts are stable when start is seen.
module trig_capture
    import trig_capture_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 1024,
    parameter int THRESH = 240,
    parameter int TRIG_W = 8,
    parameter int SKIP_W = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = AW + 1,
    localparam int LVL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [TRIG_W-1:0] trig_skip,
    input  logic [SKIP_W-1:0] samp_skip,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [2:0]        state,
    output logic [CW-1:0]     captured,
    output logic              done_pulse,
    output logic              active
);

    cap_state_e cur_st, nxt_st;

    logic hit;
    logic trig_load, trig_dec, trig_zero, trig_one_unused;
    logic samp_load, samp_dec, samp_zero, samp_one;
    logic addr_clr, addr_inc, addr_last;
    logic finish, done_r;
    logic start_ok;

    tc_level_detect #(
        .LVL_W  (LVL_W),
        .THRESH (THRESH)
    ) u_detect (
        .valid (s_valid),
        .level (s_data[DATA_W-1 -: LVL_W]),
        .hit   (hit)
    );

    tc_skip_counter #(.W(TRIG_W)) u_trig_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (trig_load),
        .load_val (trig_skip),
        .dec      (trig_dec),
        .at_zero  (trig_zero),
        .at_one   (trig_one_unused)
    );

    tc_skip_counter #(.W(SKIP_W)) u_samp_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (samp_load),
        .load_val (samp_skip),
        .dec      (samp_dec),
        .at_zero  (samp_zero),
        .at_one   (samp_one)
    );

    tc_write_addr #(.DEPTH(DEPTH)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (addr_clr),
        .inc     (addr_inc),
        .addr    (mem_addr),
        .count   (captured),
        .at_last (addr_last)
    );

    // Start is honoured only when no run is in progress.
    always_comb begin
        start_ok = start && ((cur_st == ST_IDLE) || (cur_st == ST_DONE));
    end

    // Sequencer: next state and the strobes for counters and address.
    always_comb begin
        nxt_st    = cur_st;
        trig_load = 1'b0;
        trig_dec  = 1'b0;
        samp_load = 1'b0;
        samp_dec  = 1'b0;
        addr_clr  = 1'b0;
        addr_inc  = 1'b0;
        finish    = 1'b0;
        unique case (cur_st)
            ST_IDLE, ST_DONE: begin
                if (start_ok) begin
                    nxt_st    = ST_WAIT;
                    trig_load = 1'b1;
                    samp_load = 1'b1;
                    addr_clr  = 1'b1;
                end
            end
            ST_WAIT: begin
                if (hit) begin
                    if (trig_zero) begin
                        nxt_st = samp_zero ? ST_CAPT : ST_HOLD;
                    end else begin
                        trig_dec = 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (s_valid) begin
                    samp_dec = 1'b1;
                    if (samp_one) begin
                        nxt_st = ST_CAPT;
                    end
                end
            end
            ST_CAPT: begin
                if (s_valid) begin
                    addr_inc = 1'b1;
                    if (addr_last) begin
                        nxt_st = ST_DONE;
                        finish = 1'b1;
                    end
                end
            end
            default: nxt_st = ST_IDLE;
        endcase
    end

    // State register and registered completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_st <= ST_IDLE;
            done_r <= 1'b0;
        end else begin
            cur_st <= nxt_st;
            done_r <= finish;
        end
    end

    // Buffer write port and status outputs.
    always_comb begin
        mem_we     = (cur_st == ST_CAPT) && s_valid;
        mem_wdata  = s_data;
        state      = cur_st;
        done_pulse = done_r;
        active     = (cur_st == ST_WAIT) || (cur_st == ST_HOLD) || (cur_st == ST_CAPT);
    end

endmodule

// File: rtl/trig_capture_chk.sv
// Protocol checker for trig_capture, attached by bind; observes ports only.
// Assumes: reset is synchronous and active low.
module trig_capture_chk #(
    parameter int DEPTH  = 1024,
    parameter int THRESH = 240,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = AW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          s_valid,
    input logic [7:0]    hi_byte,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [2:0]    state,
    input logic [CW-1:0] captured,
    input logic          done_pulse
);

    localparam logic [2:0] S_IDLE = 3'd0;
    localparam logic [2:0] S_WAIT = 3'd1;
    localparam logic [2:0] S_HOLD = 3'd2;
    localparam logic [2:0] S_CAPT = 3'd3;
    localparam logic [2:0] S_DONE = 3'd4;

    assert_below_threshold_waits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && s_valid && hi_byte < 8'(THRESH)) |=> state == S_WAIT);

    assert_hold_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HOLD && !s_valid) |=> state == S_HOLD);

    assert_first_write_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && captured == '0) |-> mem_addr == '0);

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        captured <= CW'(DEPTH));

    assert_done_follows_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (state == S_DONE && $past(state) == S_CAPT));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    assert_start_ignored_in_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HOLD && start && !s_valid) |=> state == S_HOLD);

    assert_reset_to_idle_R9: assert property (@(posedge clk)
        !rst_n |=> (state == S_IDLE && captured == '0));

endmodule

bind trig_capture trig_capture_chk #(
    .DEPTH  (DEPTH),
    .THRESH (THRESH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .s_valid    (s_valid),
    .hi_byte    (s_data[DATA_W-1 -: 8]),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .state      (state),
    .captured   (captured),
    .done_pulse (done_pulse)
);

// File: tb/trig_capture_tb.sv
module trig_capture_tb;

    localparam int DEPTH = 8;
    localparam int AW    = 3;
    localparam int CW    = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [7:0]       trig_skip = '0;
    logic [15:0]      samp_skip = '0;
    logic             s_valid = 1'b0;
    logic [15:0]      s_data = '0;
    logic             mem_we;
    logic [AW-1:0]    mem_addr;
    logic [15:0]      mem_wdata;
    logic [2:0]       state;
    logic [CW-1:0]    captured;
    logic             done_pulse;
    logic             active;

    int n_checks = 0;
    int n_fail   = 0;
    int wr_cnt   = 0;
    int addr_err = 0;
    int done_cnt = 0;
    logic [15:0] shadow [DEPTH];

    always #5 clk = ~clk;

    trig_capture #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .trig_skip(trig_skip),
        .samp_skip(samp_skip), .s_valid(s_valid), .s_data(s_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .state(state), .captured(captured), .done_pulse(done_pulse), .active(active)
    );

    // Buffer model: records writes mid-cycle and checks address order.
    always @(negedge clk) begin
        if (mem_we) begin
            if (wr_cnt < DEPTH) shadow[wr_cnt] = mem_wdata;
            if (int'(mem_addr) != wr_cnt) addr_err = addr_err + 1;
            wr_cnt = wr_cnt + 1;
        end
        if (done_pulse) done_cnt = done_cnt + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    // Drive one cycle of input; returns 2 ns after the edge that consumed it.
    task automatic put(input bit v, input logic [15:0] d);
        s_valid = v;
        s_data  = d;
        @(posedge clk);
        #2;
    endtask

    task automatic do_start(input int ts, input int ss);
        start = 1'b1;
        trig_skip = 8'(ts);
        samp_skip = 16'(ss);
        put(1'b0, 16'h0000);
        start = 1'b0;
    endtask

    task automatic clear_model();
        wr_cnt = 0;
        addr_err = 0;
        done_cnt = 0;
    endtask

    // Vector table: {trig_skip[8], samp_skip[16], gap[1], base[16]}
    localparam logic [40:0] VEC [4] = '{
        {8'd1, 16'd5, 1'b0, 16'h1200},
        {8'd0, 16'd0, 1'b1, 16'h0A00},
        {8'd3, 16'd2, 1'b1, 16'hF0F0},
        {8'd2, 16'd9, 1'b0, 16'h3355}
    };

    initial begin
        #1500000;
        n_fail++;
        $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R9/R10 reset state
        repeat (3) @(posedge clk);
        #2;
        chk_eq("R9 reset state", int'(state), 0);
        chk_eq("R9 reset captured", int'(captured), 0);
        chk_eq("R10 reset active", int'(active), 0);
        chk_eq("R9 reset done", int'(done_pulse), 0);
        rst_n = 1'b1;
        put(1'b0, 16'h0);

        // Vector loop: full runs, each started from the previous done state (R8)
        for (int v = 0; v < 4; v++) begin
            int ts, ss, gp, base;
            ts   = int'(VEC[v][40:33]);
            ss   = int'(VEC[v][32:17]);
            gp   = int'(VEC[v][16]);
            base = int'(VEC[v][15:0]);
            clear_model();
            do_start(ts, ss);
            chk_eq("R8 start arms", int'(state), 1);
            chk_eq("R8 captured cleared", int'(captured), 0);
            chk_eq("R10 active while armed", int'(active), 1);
            for (int i = 0; i < 3; i++) put(1'b1, 16'hEF00 + 16'(i));
            for (int t = 0; t <= ts; t++) begin
                put(1'b0, 16'hFFFF);
                put(1'b1, 16'hF000 + 16'(t));
                if (t < ts) chk_eq("R3 event ignored", int'(state), 1);
            end
            chk_eq("R4 after accepted trigger", int'(state), (ss == 0) ? 3 : 2);
            for (int k = 0; k < ss; k++) put(1'b1, 16'hF800 + 16'(k));
            chk_eq("R4 holdoff over", int'(state), 3);
            chk_eq("R4 nothing stored yet", wr_cnt, 0);
            for (int j = 0; j < DEPTH; j++) begin
                if (gp != 0) put(1'b0, 16'hF0F0);
                put(1'b1, 16'(base + j));
            end
            chk_eq("R7 done pulse", int'(done_pulse), 1);
            chk_eq("R7 done state", int'(state), 4);
            chk_eq("R7 inactive", int'(active), 0);
            put(1'b0, 16'h0);
            chk_eq("R7 pulse one cycle", int'(done_pulse), 0);
            put(1'b1, 16'hF100);
            chk_eq("R7 no write after done", wr_cnt, DEPTH);
            chk_eq("R6 captured", int'(captured), DEPTH);
            chk_eq("R6 address order", addr_err, 0);
            chk_eq("R7 done count", done_cnt, 1);
            for (int j = 0; j < DEPTH; j++)
                chk_eq("R6 stored word", int'(shadow[j]), (base + j) & 16'hFFFF);
            put(1'b0, 16'h0);
        end

        // R2 threshold boundary and R4 zero holdoff, R1 invalid trigger-level word
        clear_model();
        do_start(0, 0);
        put(1'b1, 16'hEFFF);
        chk_eq("R2 239 not a trigger", int'(state), 1);
        put(1'b0, 16'hFF00);
        chk_eq("R1 invalid word ignored", int'(state), 1);
        put(1'b1, 16'hF000);
        chk_eq("R2 240 triggers R4 direct", int'(state), 3);
        put(1'b0, 16'h0);
        chk_eq("R4 trigger word not stored", wr_cnt, 0);
        rst_n = 1'b0;
        put(1'b0, 16'h0);
        rst_n = 1'b1;
        chk_eq("R9 reset from capture", int'(state), 0);

        // R5 holdoff counts only valid words; R8 start ignored mid-run
        clear_model();
        do_start(0, 3);
        put(1'b1, 16'hFA00);
        chk_eq("R5 in holdoff", int'(state), 2);
        for (int i = 0; i < 6; i++) put(1'b0, 16'h1111);
        chk_eq("R5 idle cycles hold", int'(state), 2);
        start = 1'b1; trig_skip = 8'd5; samp_skip = 16'd7;
        put(1'b0, 16'h0);
        start = 1'b0;
        chk_eq("R8 start ignored in holdoff", int'(state), 2);
        put(1'b1, 16'h0001);
        put(1'b1, 16'h0002);
        chk_eq("R5 two of three", int'(state), 2);
        put(1'b1, 16'h0003);
        chk_eq("R5 holdoff done", int'(state), 3);
        put(1'b1, 16'h4444);
        put(1'b1, 16'h4445);
        start = 1'b1;
        put(1'b0, 16'h0);
        start = 1'b0;
        chk_eq("R8 start ignored in capture", int'(state), 3);
        chk_eq("R8 count kept", int'(captured), 2);
        chk_eq("R6 first stored after holdoff", int'(shadow[0]), 16'h4444);
        rst_n = 1'b0;
        put(1'b0, 16'h0);
        chk_eq("R9 captured cleared", int'(captured), 0);
        chk_eq("R10 inactive after reset", int'(active), 0);
        rst_n = 1'b1;
        put(1'b0, 16'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule